// File: doc/BRIEF.md
# I2C Target Receive Engine with Status Codes

This block is the receive half of an I2C target. It samples the SCL and SDA lines through synchronizers, finds START, repeated START and STOP conditions, and shifts in address and data bytes. Address bytes are compared with a programmable own address, in either 7-bit or 10-bit form. The general call address can also be matched. The block acknowledges by pulling SDA low during the ninth clock.

Software follows every bus event through an 8-bit status code and an interrupt flag. While the flag is set after an acknowledged byte, the block holds SCL low. Software reads the status and the received byte, then clears the flag with a one-cycle pulse to let the transfer go on. An assert-acknowledge control bit decides whether the block acknowledges. A second input reports that a master on the same device lost arbitration just before the address phase, and this changes the codes reported for the address.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset, status reads F8h, the flag is 0, and neither SDA nor SCL is driven low.
- R2: A 7-bit own address received after START, followed by a direction bit of 0 (byte = {addr[6:0],0}), is acknowledged only while assert-acknowledge is 1. The flag is then set after the acknowledge clock and status loads 60h.
- R3: If the arbitration-lost input pulsed before the address byte completed, a matched own address loads 68h instead of 60h, and a matched general call loads 78h instead of 70h.
- R4: With general-call enable at 1 (and assert-acknowledge at 1), the address byte 00h is acknowledged and loads 70h. With general-call enable at 0, that byte is not acknowledged and the flag stays 0.
- R5: A data byte in a transfer to the own address is acknowledged and loads 80h when assert-acknowledge is 1. The byte is on the data output, MSB first on the bus, by the time the flag sets, and it does not change while the flag stays set.
- R6: If assert-acknowledge is 0 when a data byte completes, that byte is not acknowledged and status loads 88h (own address transfer). Clearing the flag then returns status to F8h. While assert-acknowledge stays 0, the own address is not acknowledged and the flag is not set.
- R7: Data bytes after a general call load 90h when acknowledged and 98h when not acknowledged.
- R8: A STOP or repeated START that arrives right after an acknowledged data or address phase sets the flag and loads A0h. Clearing the flag returns status to F8h, and the block waits for a fresh START.
- R9: In 10-bit mode, the first address byte {11110, addr[9:8], 0} is acknowledged without setting the flag or changing status. A matching second byte addr[7:0] is acknowledged and loads 60h. A mismatched second byte is not acknowledged.
- R10: While the flag is set after an acknowledged byte, SCL is held low and the transfer cannot go on. Clearing the flag releases SCL on the next cycle.
- R11: A matching own address with direction bit 1 (read) is not acknowledged, the flag stays 0 and status stays F8h.
- R12: An address byte that matches neither the own address nor an enabled general call is not acknowledged and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low (acknowledge) |
| ctlAak | input | 1 | Assert-acknowledge control bit |
| ctlGce | input | 1 | General call enable |
| ctlAddr10 | input | 1 | 1 selects 10-bit own address |
| ownAddr | input | 10 | Own address (7-bit form uses bits 6:0) |
| arbLost | input | 1 | Pulse: local master lost arbitration |
| flagClr | input | 1 | Pulse: software clears the interrupt flag |
| intFlag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| rxData | output | 8 | Last received data byte |

## Verification
The hardest condition to reach is a STOP or repeated START that follows an acknowledged byte. It needs a byte to be acknowledged, the stretch to be released by a flag clear, and then a single SCL rise before SDA moves while SCL is high. The bench uses a wired-AND bus model in which the master waits for SCL to actually go high. This lets it first confirm that SCL stays low under the stretch, then clear the flag and issue the STOP or repeated START within the same transfer. The 10-bit path and the arbitration-lost codes are reached the same way, by chaining address bytes or by pulsing the arbitration input just before the START.

// File: rtl/i2c_rx_target_pkg.sv
package i2c_rx_target_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [7:0] CODE_IDLE     = 8'hF8;
  localparam logic [7:0] CODE_OWN      = 8'h60;
  localparam logic [7:0] CODE_OWN_ARB  = 8'h68;
  localparam logic [7:0] CODE_GC       = 8'h70;
  localparam logic [7:0] CODE_GC_ARB   = 8'h78;
  localparam logic [7:0] CODE_DAT_ACK  = 8'h80;
  localparam logic [7:0] CODE_DAT_NACK = 8'h88;
  localparam logic [7:0] CODE_GCD_ACK  = 8'h90;
  localparam logic [7:0] CODE_GCD_NACK = 8'h98;
  localparam logic [7:0] CODE_STOP     = 8'hA0;

  localparam logic [4:0] TEN_BIT_HDR = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR2, ST_DATA, ST_ACK, ST_HOLD, ST_WAIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    NX_ADDR2, NX_HOLD, NX_WAIT
  } ackNext_t;

  typedef struct packed {
    logic       sampleEn;
    logic       clrBits;
    logic       loadRx;
    logic       setFlag;
    logic       setIdle;
    logic [7:0] code;
  } dpCmd_t;

endpackage

// File: rtl/i2c_rx_target_datapath.sv
module i2c_rx_target_datapath
  import i2c_rx_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              flagClr,
  input  dpCmd_t            cmd,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] shiftByte,
  output logic [BYTE_W-1:0] rxData,
  output logic [7:0]        status,
  output logic              intFlag
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic sclS, sdaS, sclPrev, sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic sclQ, sdaQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] sclQ, sdaQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclQ <= '1;
          sdaQ <= '1;
        end else begin
          sclQ <= {sclQ[SYNC_STAGES-2:0], sclIn};
          sdaQ <= {sdaQ[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclQ[SYNC_STAGES-1];
      assign sdaS = sdaQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // bit shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftByte <= '0;
    end else if (cmd.clrBits) begin
      bitCnt <= '0;
    end else if (cmd.sampleEn && sclRise && (bitCnt < FULL_CNT)) begin
      shiftByte <= {shiftByte[BYTE_W-2:0], sdaS};
      bitCnt    <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (cmd.loadRx) begin
      rxData <= shiftByte;
    end
  end

  // status and interrupt flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlag <= 1'b0;
      status  <= CODE_IDLE;
    end else if (cmd.setFlag) begin
      intFlag <= 1'b1;
      status  <= cmd.code;
    end else begin
      if (flagClr) intFlag <= 1'b0;
      if (cmd.setIdle) status <= CODE_IDLE;
    end
  end

  p_clear_drops_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && intFlag && !cmd.setFlag) |=> !intFlag);

  p_flag_code_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> (status[2:0] == 3'b000 && status != CODE_IDLE));

  p_rx_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClr) |=> $stable(rxData));

  p_bitcnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);

endmodule

// File: rtl/i2c_rx_target_ctrl.sv
module i2c_rx_target_ctrl
  import i2c_rx_target_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] shiftByte,
  input  logic              intFlag,
  input  logic              flagClr,
  input  logic              ctlAak,
  input  logic              ctlGce,
  input  logic              ctlAddr10,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              arbLost,
  output dpCmd_t            cmd,
  output logic              sdaOe,
  output logic              sclOe
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  ctrlState_t state, stateN;
  ackNext_t   ackNext, ackNextN;
  logic [7:0] pendCode, pendN;
  logic       arbSeen, arbN, gcXfer, gcN, sdaOeN, sclOeN;

  logic byteDone, own7Hit, tenHdrHit, tenLowHit, gcHit, afterAck;

  assign byteDone  = (bitCnt == FULL_CNT) && sclFall;
  assign own7Hit   = !ctlAddr10 && (shiftByte == {ownAddr[6:0], 1'b0});
  assign tenHdrHit = ctlAddr10 && (shiftByte == {TEN_BIT_HDR, ownAddr[9:8], 1'b0});
  assign tenLowHit = (shiftByte == ownAddr[7:0]);
  assign gcHit     = ctlGce && (shiftByte == '0);
  assign afterAck  = (bitCnt <= CNT_W'(1));

  always_comb begin
    stateN   = state;
    ackNextN = ackNext;
    pendN    = pendCode;
    gcN      = gcXfer;
    arbN     = arbSeen | arbLost;
    sdaOeN   = sdaOe;
    sclOeN   = sclOe;
    cmd      = '0;
    cmd.code = pendCode;

    unique case (state)
      ST_IDLE: begin
        if (startDet) begin
          stateN      = ST_ADDR;
          cmd.clrBits = 1'b1;
        end
      end

      ST_ADDR: begin
        cmd.sampleEn = 1'b1;
        if (startDet) begin
          cmd.clrBits = 1'b1;
        end else if (stopDet) begin
          stateN = ST_IDLE;
          arbN   = 1'b0;
        end else if (byteDone) begin
          if (ctlAak && own7Hit) begin
            sdaOeN   = 1'b1;
            pendN    = arbSeen ? CODE_OWN_ARB : CODE_OWN;
            gcN      = 1'b0;
            arbN     = 1'b0;
            ackNextN = NX_HOLD;
            stateN   = ST_ACK;
          end else if (ctlAak && tenHdrHit) begin
            sdaOeN   = 1'b1;
            ackNextN = NX_ADDR2;
            stateN   = ST_ACK;
          end else if (ctlAak && gcHit) begin
            sdaOeN   = 1'b1;
            pendN    = arbSeen ? CODE_GC_ARB : CODE_GC;
            gcN      = 1'b1;
            arbN     = 1'b0;
            ackNextN = NX_HOLD;
            stateN   = ST_ACK;
          end else begin
            arbN   = 1'b0;
            stateN = ST_IDLE;
          end
        end
      end

      ST_ADDR2: begin
        cmd.sampleEn = 1'b1;
        if (startDet) begin
          cmd.clrBits = 1'b1;
          stateN      = ST_ADDR;
        end else if (stopDet) begin
          stateN = ST_IDLE;
          arbN   = 1'b0;
        end else if (byteDone) begin
          arbN = 1'b0;
          if (ctlAak && tenLowHit) begin
            sdaOeN   = 1'b1;
            pendN    = arbSeen ? CODE_OWN_ARB : CODE_OWN;
            gcN      = 1'b0;
            ackNextN = NX_HOLD;
            stateN   = ST_ACK;
          end else begin
            stateN = ST_IDLE;
          end
        end
      end

      ST_DATA: begin
        cmd.sampleEn = 1'b1;
        if ((startDet || stopDet) && afterAck) begin
          cmd.setFlag = 1'b1;
          cmd.code    = CODE_STOP;
          stateN      = ST_WAIT;
        end else if (startDet) begin
          cmd.clrBits = 1'b1;
          stateN      = ST_ADDR;
        end else if (stopDet) begin
          stateN = ST_IDLE;
        end else if (byteDone) begin
          cmd.loadRx = 1'b1;
          stateN     = ST_ACK;
          if (ctlAak) begin
            sdaOeN   = 1'b1;
            pendN    = gcXfer ? CODE_GCD_ACK : CODE_DAT_ACK;
            ackNextN = NX_HOLD;
          end else begin
            pendN    = gcXfer ? CODE_GCD_NACK : CODE_DAT_NACK;
            ackNextN = NX_WAIT;
          end
        end
      end

      ST_ACK: begin
        if (sclFall) begin
          sdaOeN      = 1'b0;
          cmd.clrBits = 1'b1;
          unique case (ackNext)
            NX_ADDR2: stateN = ST_ADDR2;
            NX_HOLD: begin
              cmd.setFlag = 1'b1;
              sclOeN      = 1'b1;
              stateN      = ST_HOLD;
            end
            default: begin
              cmd.setFlag = 1'b1;
              stateN      = ST_WAIT;
            end
          endcase
        end
      end

      ST_HOLD: begin
        if (flagClr && intFlag) begin
          sclOeN = 1'b0;
          stateN = ST_DATA;
        end
      end

      ST_WAIT: begin
        if (flagClr && intFlag) begin
          cmd.setIdle = 1'b1;
          stateN      = ST_IDLE;
        end
      end

      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackNext  <= NX_HOLD;
      pendCode <= CODE_IDLE;
      arbSeen  <= 1'b0;
      gcXfer   <= 1'b0;
      sdaOe    <= 1'b0;
      sclOe    <= 1'b0;
    end else begin
      state    <= stateN;
      ackNext  <= ackNextN;
      pendCode <= pendN;
      arbSeen  <= arbN;
      gcXfer   <= gcN;
      sdaOe    <= sdaOeN;
      sclOe    <= sclOeN;
    end
  end

  p_stretch_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> intFlag);

  p_release_on_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && flagClr) |=> !sclOe);

  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> (bitCnt == FULL_CNT));

  p_no_ack_without_aak_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(ctlAak));

endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
  import i2c_rx_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe,
  input  logic        ctlAak,
  input  logic        ctlGce,
  input  logic        ctlAddr10,
  input  logic [9:0]  ownAddr,
  input  logic        arbLost,
  input  logic        flagClr,
  output logic        intFlag,
  output logic [7:0]  status,
  output logic [7:0]  rxData
);

  dpCmd_t             cmd;
  logic               sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]  shiftByte;

  i2c_rx_target_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .flagClr   (flagClr),
    .cmd       (cmd),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .bitCnt    (bitCnt),
    .shiftByte (shiftByte),
    .rxData    (rxData),
    .status    (status),
    .intFlag   (intFlag)
  );

  i2c_rx_target_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .bitCnt    (bitCnt),
    .shiftByte (shiftByte),
    .intFlag   (intFlag),
    .flagClr   (flagClr),
    .ctlAak    (ctlAak),
    .ctlGce    (ctlGce),
    .ctlAddr10 (ctlAddr10),
    .ownAddr   (ownAddr),
    .arbLost   (arbLost),
    .cmd       (cmd),
    .sdaOe     (sdaOe),
    .sclOe     (sclOe)
  );

  logic unusedRise;
  assign unusedRise = sclRise;

endmodule

// File: tb/i2c_rx_target_test.sv
`timescale 1ns/1ps
module i2c_rx_target_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclBus, sdaBus;
  logic sclOe, sdaOe;
  logic ctlAak = 1'b1, ctlGce = 1'b0, ctlAddr10 = 1'b0;
  logic [9:0] ownAddr = 10'h02A;
  logic arbLost = 1'b0, flagClr = 1'b0;
  logic intFlag;
  logic [7:0] status, rxData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  assign sclBus = sclM & ~sclOe;
  assign sdaBus = sdaM & ~sdaOe;

  i2c_rx_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclOe(sclOe), .sdaOe(sdaOe), .ctlAak(ctlAak), .ctlGce(ctlGce),
    .ctlAddr10(ctlAddr10), .ownAddr(ownAddr), .arbLost(arbLost),
    .flagClr(flagClr), .intFlag(intFlag), .status(status), .rxData(rxData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    sclM = 1'b1;
    for (int i = 0; i < 400 && !sclBus; i++) @(negedge clk);
    if (!sclBus) chk("R10 scl never released", 0, 1);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(4);
    sclHigh(); tick(4);
    sclM = 1'b0; tick(4);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(4);
    sclHigh(); tick(2);
    ack = ~sdaBus; tick(2);
    sclM = 1'b0; tick(6);
  endtask

  task automatic startC();
    sdaM = 1'b1; sclHigh(); tick(4);
    sdaM = 1'b0; tick(4);
    sclM = 1'b0; tick(4);
  endtask

  task automatic repStartC();
    sdaM = 1'b1; tick(4);
    sclHigh(); tick(4);
    sdaM = 1'b0; tick(4);
    sclM = 1'b0; tick(6);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(4);
    sclHigh(); tick(4);
    sdaM = 1'b1; tick(6);
  endtask

  task automatic pulseClr();
    flagClr = 1'b1; tick(1); flagClr = 1'b0; tick(2);
  endtask

  task automatic pulseArb();
    arbLost = 1'b1; tick(1); arbLost = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'hF8);
    chk("R1 flag", intFlag, 0);
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 sclOe", sclOe, 0);
  endtask

  task automatic t_own();
    logic ack;
    startC();
    sendByte(8'h54, ack);
    chk("R2 addr ack", ack, 1);
    chk("R2 status", status, 8'h60);
    chk("R2 flag", intFlag, 1);
    chk("R10 stretch on", sclOe, 1);
    sdaM = 1'b1; sclM = 1'b1; tick(30);
    chk("R10 scl held", sclBus, 0);
    chk("R10 status kept", status, 8'h60);
    sclM = 1'b0; tick(4);
    pulseClr();
    chk("R10 released", sclOe, 0);
    chk("R10 flag cleared", intFlag, 0);
    sendByte(8'hA5, ack);
    chk("R5 data ack", ack, 1);
    chk("R5 status", status, 8'h80);
    chk("R5 rxData", rxData, 8'hA5);
    pulseClr();
    stopC();
    chk("R8 stop status", status, 8'hA0);
    chk("R8 stop flag", intFlag, 1);
    chk("R8 no stretch", sclOe, 0);
    pulseClr();
    chk("R8 idle status", status, 8'hF8);
    chk("R8 flag cleared", intFlag, 0);
  endtask

  task automatic t_nack();
    logic ack;
    startC();
    sendByte(8'h54, ack);
    chk("R2 addr ack again", status, 8'h60);
    pulseClr();
    ctlAak = 1'b0;
    sendByte(8'h3C, ack);
    chk("R6 data nack", ack, 0);
    chk("R6 status", status, 8'h88);
    chk("R6 flag", intFlag, 1);
    chk("R6 no stretch", sclOe, 0);
    chk("R5 rxData on nack", rxData, 8'h3C);
    pulseClr();
    chk("R6 idle after clear", status, 8'hF8);
    stopC();
    startC();
    sendByte(8'h54, ack);
    chk("R6 addr nack aak0", ack, 0);
    chk("R6 no flag aak0", intFlag, 0);
    chk("R6 status aak0", status, 8'hF8);
    stopC();
    ctlAak = 1'b1;
  endtask

  task automatic t_gc();
    logic ack;
    ctlGce = 1'b1;
    startC();
    sendByte(8'h00, ack);
    chk("R4 gc ack", ack, 1);
    chk("R4 gc status", status, 8'h70);
    pulseClr();
    sendByte(8'h11, ack);
    chk("R7 gc data ack", ack, 1);
    chk("R7 gc data status", status, 8'h90);
    pulseClr();
    ctlAak = 1'b0;
    sendByte(8'h22, ack);
    chk("R7 gc data nack", ack, 0);
    chk("R7 gc nack status", status, 8'h98);
    chk("R7 gc rxData", rxData, 8'h22);
    pulseClr();
    ctlAak = 1'b1;
    stopC();
    chk("R7 idle", status, 8'hF8);
    ctlGce = 1'b0;
    startC();
    sendByte(8'h00, ack);
    chk("R4 gc disabled nack", ack, 0);
    chk("R4 gc disabled flag", intFlag, 0);
    stopC();
  endtask

  task automatic t_arb();
    logic ack;
    pulseArb();
    startC();
    sendByte(8'h54, ack);
    chk("R3 own arb ack", ack, 1);
    chk("R3 own arb status", status, 8'h68);
    pulseClr();
    stopC();
    pulseClr();
    ctlGce = 1'b1;
    pulseArb();
    startC();
    sendByte(8'h00, ack);
    chk("R3 gc arb status", status, 8'h78);
    pulseClr();
    stopC();
    pulseClr();
    ctlGce = 1'b0;
    startC();
    sendByte(8'h54, ack);
    chk("R3 arb not sticky", status, 8'h60);
    pulseClr();
    stopC();
    pulseClr();
  endtask

  task automatic t_ten();
    logic ack;
    ctlAddr10 = 1'b1; ownAddr = 10'h2B5;
    startC();
    sendByte(8'hF4, ack);
    chk("R9 hdr ack", ack, 1);
    chk("R9 hdr no flag", intFlag, 0);
    chk("R9 hdr status", status, 8'hF8);
    sendByte(8'hB5, ack);
    chk("R9 low ack", ack, 1);
    chk("R9 low status", status, 8'h60);
    pulseClr();
    repStartC();
    chk("R8 rep start status", status, 8'hA0);
    pulseClr();
    stopC();
    startC();
    sendByte(8'hF4, ack);
    sendByte(8'hB4, ack);
    chk("R9 low mismatch nack", ack, 0);
    chk("R9 low mismatch flag", intFlag, 0);
    stopC();
    ctlAddr10 = 1'b0; ownAddr = 10'h02A;
  endtask

  task automatic t_read();
    logic ack;
    startC();
    sendByte(8'h55, ack);
    chk("R11 read nack", ack, 0);
    chk("R11 read flag", intFlag, 0);
    chk("R11 read status", status, 8'hF8);
    stopC();
    startC();
    sendByte(8'h56, ack);
    chk("R12 mismatch nack", ack, 0);
    chk("R12 mismatch flag", intFlag, 0);
    stopC();
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    t_reset();
    t_own();
    t_nack();
    t_gc();
    t_arb();
    t_ten();
    t_read();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule